// File: doc/BRIEF.md
# Vectored Interrupt Entry and Exit Sequencer

This block gathers up to 32 interrupt lines and holds each one as pending until it is served. It then picks a single winner, either by fixed priority or by rotating priority, and shows the core one request flag with the winner's 5-bit vector number. When the core accepts, the block drops the global interrupt enable, works out the handler fetch address, and walks the entry sequence: fetch the handler, start the register save, then start the handler.

When the core signals that the handler has finished, the block runs the exit sequence in a fixed order. It disables interrupts, releases the context frame, then starts the register restore. When the restore reports done, the enable flag goes back to the value it had when the request was accepted.

The instruction fetch, the save/restore engine and the context memory are outside this block. It drives them only through start pulses and done inputs. Software reads and writes the base, enable, policy and mask registers through a small special-register port.

Top module: `irq_seq`

## Requirements
- R1: A one-cycle high on `irq_lines_i[k]` sets pending bit k. The bit stays set until vector k is accepted. A pending line whose mask bit (register 3, bit k) is 0 takes no part in arbitration and raises no request. Once the mask bit is set, the line is presented.
- R2: `irq_req_o` is high exactly when all three hold: the enable flag is 1, the sequencer is idle, and at least one pending line is unmasked. `irq_vec_o` gives the winner's index in 5 bits.
- R3: With policy bit 0 of register 2 at 0 (fixed priority), the lowest-numbered eligible line wins.
- R4: With policy bit 0 at 1 (round robin), the search starts one index above the last accepted vector and wraps from 31 to 0.
- R5: If `irq_ack_i` is high while `irq_req_o` is high, then in the next cycle the enable flag reads 0, the request drops and the winner's pending bit is cleared. If `irq_ack_i` is high while no request is shown, it has no effect.
- R6: One cycle after acceptance, `fetch_start_o` pulses for one cycle. At the same time `fetch_addr_o` equals the base register plus the vector times 64 (vector shifted left by 6), modulo 2^32.
- R7: `backup_start_o` pulses in the cycle after `fetch_done_i` is seen while waiting for the fetch. `handler_start_o` pulses in the cycle after that.
- R8: From acceptance until the exit completes, hardware never sets the enable flag. Only a software write of bit 0 to register 1 can set it.
- R9: When `exit_req_i` is high while the handler runs, the enable flag reads 0 in the next cycle. One cycle later `free_start_o` pulses. `restore_start_o` pulses in the cycle after `free_done_i` is seen.
- R10: When `restore_done_i` is seen after the restore has started, the sequencer becomes idle. In that same cycle the enable flag takes back its value from the moment of acceptance.
- R11: Reset clears all pending bits and the enable flag, selects fixed priority, sets the base register to 0 and sets the mask register to all ones.
- R12: Register map on the special-register port: 0 is the base, 1 is the enable flag in bit 0, 2 is the policy in bit 0, and 3 is the mask. A write takes effect at the clock edge when `sr_we_i` is high. `sr_rdata_o` shows the register at `sr_addr_i` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_lines_i | input | 32 | Interrupt request lines |
| irq_req_o | output | 1 | Request toward the core |
| irq_vec_o | output | 5 | Winning vector number |
| irq_ack_i | input | 1 | Core accepts the request |
| fetch_start_o | output | 1 | Start the handler fetch |
| fetch_addr_o | output | 32 | Handler fetch address |
| fetch_done_i | input | 1 | Handler fetch finished |
| backup_start_o | output | 1 | Start the register save |
| handler_start_o | output | 1 | Start the handler |
| exit_req_i | input | 1 | Handler has finished |
| free_start_o | output | 1 | Release the context frame |
| free_done_i | input | 1 | Context frame released |
| restore_start_o | output | 1 | Start the register restore |
| restore_done_i | input | 1 | Register restore finished |
| sr_we_i | input | 1 | Special-register write strobe |
| sr_addr_i | input | 2 | Special-register index |
| sr_wdata_i | input | 32 | Special-register write data |
| sr_rdata_o | output | 32 | Special-register read data |

## Verification
The bench covers these corner cases:
- **Round-robin wrap from 31 to 0.** A pointer that fails to wrap would skip line 0 or pick a stale line.
- **Several lines pending at once under fixed priority.** A wrong scan order would pick a higher-numbered line first.
- **A masked line held pending, then unmasked.** Dropping the bit at the mask would lose the line, and ignoring the mask would raise a request too early.
- **A base near the top of the address space with vector 31.** This exposes a shift or carry error in the address.
- **An acknowledge with no request shown.** A design that accepts it would start a fetch that nobody asked for.
- **A software re-enable during the handler.** A design that lets the exit skip the disable step would leave interrupts on while the frame is being released.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  localparam int VEC_SHIFT = 6;

  localparam logic [1:0] SR_BASE = 2'd0;
  localparam logic [1:0] SR_EN   = 2'd1;
  localparam logic [1:0] SR_POL  = 2'd2;
  localparam logic [1:0] SR_MASK = 2'd3;

  typedef enum logic [3:0] {
    S_IDLE, S_FREQ, S_FWAIT, S_BKUP, S_HSTART, S_RUN,
    S_XDIS, S_XFREE, S_XFWAIT, S_XREST, S_XRWAIT
  } seq_state_e;
endpackage

// File: rtl/irq_arb.sv
module irq_arb #(
  parameter int N  = 32,
  parameter int VW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  lines_i,
  input  logic [N-1:0]  mask_i,
  input  logic          rr_mode_i,
  input  logic          take_i,
  output logic          any_o,
  output logic [VW-1:0] win_o
);
  logic [N-1:0]  pend_q;
  logic [N-1:0]  cand;
  logic [VW-1:0] last_q;
  logic          found;
  int            idx;

  assign cand = pend_q & mask_i;

  always_comb begin
    found = 1'b0;
    win_o = '0;
    idx   = 0;
    for (int i = 0; i < N; i++) begin
      if (rr_mode_i) begin
        idx = int'(last_q) + 1 + i;
        if (idx >= N) idx = idx - N;
        if (idx >= N) idx = idx - N;
      end else begin
        idx = i;
      end
      if (!found && cand[idx]) begin
        found = 1'b1;
        win_o = idx[VW-1:0];
      end
    end
  end

  assign any_o = found;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      last_q <= VW'(N - 1);
    end else begin
      pend_q <= (pend_q & ~((take_i ? {{(N-1){1'b0}}, 1'b1} : '0) << win_o)) | lines_i;
      if (take_i) last_q <= win_o;
    end
  end

  // R1: only a pending, unmasked line can be granted
  a_r1_grant_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> (pend_q[win_o] && mask_i[win_o]));

  // R5: the accepted line is cleared unless it fires again
  a_r5_pend_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !lines_i[win_o]) |=> !pend_q[$past(win_o)]);
endmodule

// File: rtl/irq_sregs.sv
module irq_sregs
  import irq_seq_pkg::*;
#(
  parameter int N  = 32,
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sr_we_i,
  input  logic [1:0]    sr_addr_i,
  input  logic [DW-1:0] sr_wdata_i,
  output logic [DW-1:0] sr_rdata_o,
  input  logic          ack_evt_i,
  input  logic          exit_evt_i,
  input  logic          restore_evt_i,
  output logic          en_o,
  output logic          rr_o,
  output logic [AW-1:0] base_o,
  output logic [N-1:0]  mask_o
);
  logic          en_q, saved_q, rr_q;
  logic [AW-1:0] base_q;
  logic [N-1:0]  mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      saved_q <= 1'b0;
      rr_q    <= 1'b0;
      base_q  <= '0;
      mask_q  <= '1;
    end else begin
      if (ack_evt_i) saved_q <= en_q;
      // hardware clears outrank restore, restore outranks software
      if (ack_evt_i || exit_evt_i)            en_q <= 1'b0;
      else if (restore_evt_i)                 en_q <= saved_q;
      else if (sr_we_i && sr_addr_i == SR_EN) en_q <= sr_wdata_i[0];
      if (sr_we_i) begin
        case (sr_addr_i)
          SR_BASE: base_q <= AW'(sr_wdata_i);
          SR_POL:  rr_q   <= sr_wdata_i[0];
          SR_MASK: mask_q <= N'(sr_wdata_i);
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (sr_addr_i)
      SR_BASE: sr_rdata_o = DW'(base_q);
      SR_EN:   sr_rdata_o = DW'(en_q);
      SR_POL:  sr_rdata_o = DW'(rr_q);
      default: sr_rdata_o = DW'(mask_q);
    endcase
  end

  assign en_o   = en_q;
  assign rr_o   = rr_q;
  assign base_o = base_q;
  assign mask_o = mask_q;

  // R8: enable rises only from a software write or an exit restore
  a_r8_en_rise_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_q) |-> $past(restore_evt_i || (sr_we_i && sr_addr_i == SR_EN)));
endmodule

// File: rtl/irq_fsm.sv
module irq_fsm
  import irq_seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int VW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  logic [VW-1:0] vec_i,
  input  logic [AW-1:0] base_i,
  input  logic          fetch_done_i,
  input  logic          exit_req_i,
  input  logic          free_done_i,
  input  logic          restore_done_i,
  output logic          idle_o,
  output logic          exit_evt_o,
  output logic          restore_evt_o,
  output logic          fetch_start_o,
  output logic [AW-1:0] fetch_addr_o,
  output logic          backup_start_o,
  output logic          handler_start_o,
  output logic          free_start_o,
  output logic          restore_start_o
);
  seq_state_e    state_q, state_d;
  logic [AW-1:0] addr_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:   if (accept_i) state_d = S_FREQ;
      S_FREQ:   state_d = S_FWAIT;
      S_FWAIT:  if (fetch_done_i) state_d = S_BKUP;
      S_BKUP:   state_d = S_HSTART;
      S_HSTART: state_d = S_RUN;
      S_RUN:    if (exit_req_i) state_d = S_XDIS;
      S_XDIS:   state_d = S_XFREE;
      S_XFREE:  state_d = S_XFWAIT;
      S_XFWAIT: if (free_done_i) state_d = S_XREST;
      S_XREST:  state_d = S_XRWAIT;
      S_XRWAIT: if (restore_done_i) state_d = S_IDLE;
      default:  state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      if (accept_i) addr_q <= base_i + (AW'(vec_i) << VEC_SHIFT);
    end
  end

  assign idle_o          = state_q == S_IDLE;
  assign exit_evt_o      = state_q == S_RUN && exit_req_i;
  assign restore_evt_o   = state_q == S_XRWAIT && restore_done_i;
  assign fetch_start_o   = state_q == S_FREQ;
  assign fetch_addr_o    = addr_q;
  assign backup_start_o  = state_q == S_BKUP;
  assign handler_start_o = state_q == S_HSTART;
  assign free_start_o    = state_q == S_XFREE;
  assign restore_start_o = state_q == S_XREST;

  // R7: save starts only after the fetch reported done
  a_r7_backup_after_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    backup_start_o |-> $past(fetch_done_i));
  // R7: handler starts right after the save started
  a_r7_handler_after_backup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    handler_start_o |-> $past(backup_start_o));
  // R9: restore follows a released frame
  a_r9_restore_after_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_start_o |-> $past(free_done_i));
  // R9: at most one handshake start at a time
  a_r9_one_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({fetch_start_o, backup_start_o, handler_start_o, free_start_o, restore_start_o}));
endmodule

// File: rtl/irq_seq.sv
module irq_seq
  import irq_seq_pkg::*;
#(
  parameter int N  = 32,
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int VW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  irq_lines_i,
  output logic          irq_req_o,
  output logic [VW-1:0] irq_vec_o,
  input  logic          irq_ack_i,
  output logic          fetch_start_o,
  output logic [AW-1:0] fetch_addr_o,
  input  logic          fetch_done_i,
  output logic          backup_start_o,
  output logic          handler_start_o,
  input  logic          exit_req_i,
  output logic          free_start_o,
  input  logic          free_done_i,
  output logic          restore_start_o,
  input  logic          restore_done_i,
  input  logic          sr_we_i,
  input  logic [1:0]    sr_addr_i,
  input  logic [DW-1:0] sr_wdata_i,
  output logic [DW-1:0] sr_rdata_o
);
  logic          en, rr, any, idle, accept, exit_evt, restore_evt;
  logic [AW-1:0] base;
  logic [N-1:0]  mask;
  logic [VW-1:0] win;

  assign irq_req_o = en && idle && any;
  assign irq_vec_o = win;
  assign accept    = irq_req_o && irq_ack_i;

  irq_arb #(.N(N), .VW(VW)) u_arb (
    .clk_i, .rst_ni, .lines_i(irq_lines_i), .mask_i(mask), .rr_mode_i(rr),
    .take_i(accept), .any_o(any), .win_o(win)
  );

  irq_sregs #(.N(N), .AW(AW), .DW(DW)) u_sregs (
    .clk_i, .rst_ni, .sr_we_i, .sr_addr_i, .sr_wdata_i, .sr_rdata_o,
    .ack_evt_i(accept), .exit_evt_i(exit_evt), .restore_evt_i(restore_evt),
    .en_o(en), .rr_o(rr), .base_o(base), .mask_o(mask)
  );

  irq_fsm #(.AW(AW), .VW(VW)) u_fsm (
    .clk_i, .rst_ni, .accept_i(accept), .vec_i(win), .base_i(base),
    .fetch_done_i, .exit_req_i, .free_done_i, .restore_done_i,
    .idle_o(idle), .exit_evt_o(exit_evt), .restore_evt_o(restore_evt),
    .fetch_start_o, .fetch_addr_o, .backup_start_o, .handler_start_o,
    .free_start_o, .restore_start_o
  );

  // R5: acceptance drops the request and starts the fetch next cycle
  a_r5_accept_effect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> (!irq_req_o && fetch_start_o && !en));
  // R9: frame release happens with interrupts disabled
  a_r9_free_while_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(free_start_o) |-> !en);
  // R2: no request outside the idle state
  a_r2_req_only_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> !(fetch_start_o || backup_start_o || handler_start_o ||
                    free_start_o || restore_start_o));
endmodule

// File: tb/irq_seq_test.sv
module irq_seq_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] irq_lines_i = '0;
  logic        irq_req_o;
  logic [4:0]  irq_vec_o;
  logic        irq_ack_i = 1'b0;
  logic        fetch_start_o;
  logic [31:0] fetch_addr_o;
  logic        fetch_done_i = 1'b0;
  logic        backup_start_o, handler_start_o;
  logic        exit_req_i = 1'b0;
  logic        free_start_o;
  logic        free_done_i = 1'b0;
  logic        restore_start_o;
  logic        restore_done_i = 1'b0;
  logic        sr_we_i = 1'b0;
  logic [1:0]  sr_addr_i = '0;
  logic [31:0] sr_wdata_i = '0;
  logic [31:0] sr_rdata_o;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk_i = ~clk_i;

  irq_seq uut (.*);

  // behavioural reference state
  logic [31:0] m_pend, m_mask, m_base, m_faddr;
  bit          m_en, m_pol, m_saved;
  int          m_last, m_phase;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int m_win();
    for (int i = 0; i < 32; i++) begin
      int k;
      k = m_pol ? (m_last + 1 + i) % 32 : i;
      if (m_pend[k] && m_mask[k]) return k;
    end
    return -1;
  endfunction

  function automatic bit m_req();
    return m_en && m_phase == 0 && m_win() >= 0;
  endfunction

  function automatic logic [31:0] m_rd(logic [1:0] a);
    case (a)
      2'd0: return m_base;
      2'd1: return {31'b0, m_en};
      2'd2: return {31'b0, m_pol};
      default: return m_mask;
    endcase
  endfunction

  task automatic model_reset();
    m_pend = '0; m_mask = '1; m_base = '0; m_faddr = '0;
    m_en = 0; m_pol = 0; m_saved = 0; m_last = 31; m_phase = 0;
  endtask

  // advance the model over one clock edge using the inputs now applied
  task automatic model_step();
    int  w;
    bit  acc, ex, rs;
    int  np;
    w   = m_win();
    acc = m_req() && irq_ack_i;
    ex  = m_phase == 5 && exit_req_i;
    rs  = m_phase == 10 && restore_done_i;
    np  = m_phase;
    case (m_phase)
      0: if (acc) np = 1;
      1: np = 2;
      2: if (fetch_done_i) np = 3;
      3: np = 4;
      4: np = 5;
      5: if (ex) np = 6;
      6: np = 7;
      7: np = 8;
      8: if (free_done_i) np = 9;
      9: np = 10;
      10: if (rs) np = 0;
      default: np = 0;
    endcase
    if (acc) begin
      m_saved = m_en;
      m_faddr = m_base + 32'(w) * 64;
      m_pend[w] = 1'b0;
      m_last = w;
    end
    m_pend = m_pend | irq_lines_i;
    if (acc || ex) m_en = 0;
    else if (rs) m_en = m_saved;
    else if (sr_we_i && sr_addr_i == 2'd1) m_en = sr_wdata_i[0];
    if (sr_we_i) begin
      case (sr_addr_i)
        2'd0: m_base = sr_wdata_i;
        2'd2: m_pol  = sr_wdata_i[0];
        2'd3: m_mask = sr_wdata_i;
        default: ;
      endcase
    end
    m_phase = np;
  endtask

  task automatic compare();
    chk("R2 req", {31'b0, irq_req_o}, {31'b0, m_req()});
    if (m_req()) chk(m_pol ? "R4 vec" : "R3 vec", {27'b0, irq_vec_o}, 32'(m_win()));
    chk("R6 fetch_start", {31'b0, fetch_start_o}, {31'b0, m_phase == 1});
    if (m_phase == 1) chk("R6 fetch_addr", fetch_addr_o, m_faddr);
    chk("R7 backup_start", {31'b0, backup_start_o}, {31'b0, m_phase == 3});
    chk("R7 handler_start", {31'b0, handler_start_o}, {31'b0, m_phase == 4});
    chk("R9 free_start", {31'b0, free_start_o}, {31'b0, m_phase == 7});
    chk("R9 restore_start", {31'b0, restore_start_o}, {31'b0, m_phase == 9});
    chk("R12 rdata", sr_rdata_o, m_rd(sr_addr_i));
  endtask

  task automatic cyc();
    model_step();
    @(negedge clk_i);
    compare();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic sr_wr(logic [1:0] a, logic [31:0] d);
    sr_we_i = 1; sr_addr_i = a; sr_wdata_i = d;
    cyc();
    sr_we_i = 0;
  endtask

  task automatic rdchk(string tag, logic [1:0] a, logic [31:0] exp);
    sr_addr_i = a;
    #1;
    chk(tag, sr_rdata_o, exp);
  endtask

  task automatic pulse(logic [31:0] m);
    irq_lines_i = m;
    cyc();
    irq_lines_i = '0;
  endtask

  task automatic serve(string vtag, int vec, logic [31:0] addr, bit sw_en);
    int n;
    n = 0;
    while (!irq_req_o && n < 20) begin cyc(); n++; end
    chk("R2 request shown", {31'b0, irq_req_o}, 32'd1);
    chk(vtag, {27'b0, irq_vec_o}, 32'(vec));
    irq_ack_i = 1; cyc(); irq_ack_i = 0;
    rdchk("R5 enable cleared on accept", 2'd1, 32'd0);
    chk("R5 request dropped", {31'b0, irq_req_o}, 32'd0);
    chk("R6 fetch address", fetch_addr_o, addr);
    chk("R6 fetch start", {31'b0, fetch_start_o}, 32'd1);
    idle(3);
    fetch_done_i = 1; cyc(); fetch_done_i = 0;
    chk("R7 backup after fetch done", {31'b0, backup_start_o}, 32'd1);
    cyc();
    chk("R7 handler after backup", {31'b0, handler_start_o}, 32'd1);
    idle(5);
    rdchk("R8 enable stays clear", 2'd1, 32'd0);
    if (sw_en) begin
      sr_wr(2'd1, 32'd1);
      rdchk("R8 software re-enable", 2'd1, 32'd1);
    end
    exit_req_i = 1; cyc(); exit_req_i = 0;
    rdchk("R9 disable first on exit", 2'd1, 32'd0);
    chk("R9 no free yet", {31'b0, free_start_o}, 32'd0);
    cyc();
    chk("R9 free start", {31'b0, free_start_o}, 32'd1);
    idle(2);
    free_done_i = 1; cyc(); free_done_i = 0;
    chk("R9 restore after free", {31'b0, restore_start_o}, 32'd1);
    idle(2);
    restore_done_i = 1; cyc(); restore_done_i = 0;
    rdchk("R10 enable restored", 2'd1, 32'd1);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    compare();
    rdchk("R11 base reset", 2'd0, 32'd0);
    rdchk("R11 enable reset", 2'd1, 32'd0);
    rdchk("R11 policy reset", 2'd2, 32'd0);
    rdchk("R11 mask reset", 2'd3, 32'hFFFF_FFFF);
    chk("R11 no request", {31'b0, irq_req_o}, 32'd0);

    pulse(32'h0000_0038);  // lines 3,4,5
    idle(2);
    chk("R2 no request while disabled", {31'b0, irq_req_o}, 32'd0);
    sr_wr(2'd0, 32'h0000_1000);
    sr_wr(2'd1, 32'd1);
    serve("R3 lowest first", 3, 32'h0000_10C0, 0);
    serve("R3 next lowest", 4, 32'h0000_1100, 1);
    serve("R3 last", 5, 32'h0000_1140, 0);

    irq_ack_i = 1; cyc(); irq_ack_i = 0;
    chk("R5 stray ack ignored", {31'b0, fetch_start_o}, 32'd0);
    rdchk("R5 stray ack keeps enable", 2'd1, 32'd1);

    sr_wr(2'd2, 32'd1);
    pulse(32'h0000_0086);  // lines 1,2,7
    serve("R4 after last 5", 7, 32'h0000_11C0, 0);
    serve("R4 wrap", 1, 32'h0000_1040, 0);
    serve("R4 continue", 2, 32'h0000_1080, 0);

    sr_wr(2'd3, ~(32'd1 << 9));
    pulse(32'h0000_0200);
    idle(3);
    chk("R1 masked line silent", {31'b0, irq_req_o}, 32'd0);
    sr_wr(2'd3, 32'hFFFF_FFFF);
    serve("R1 unmasked line served", 9, 32'h0000_1240, 0);

    sr_wr(2'd0, 32'hFFFF_F000);
    pulse(32'h8000_0001);  // lines 0,31
    serve("R4 top vector", 31, 32'hFFFF_F7C0, 0);
    serve("R4 wrap to zero", 0, 32'hFFFF_F000, 0);

    sr_wr(2'd2, 32'd0);
    pulse(32'h8000_0400);
    serve("R3 fixed low", 10, 32'hFFFF_F280, 0);
    serve("R3 fixed high", 31, 32'hFFFF_F7C0, 0);
    idle(3);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule